// File: doc/BRIEF.md
# Erase-Block Write-Protect Lock Manager

This block holds a write-protect state for every erase block of a flash array and changes those states on command. Each block is locked, unlocked or lock-tight. Software selects a range by writing a first-block register and a last-block register, then issues one of four commands. The commands are unlock the range, unlock every block, lock the range, and lock-tight the range. The block then steps through the selected blocks in ascending order, one block per clock. A sticky interrupt request marks the end of each command.

Lock-tight is sticky, and the two directions follow different rules. A lock-tight block does not respond to unlock or lock commands. The lock-tight command itself has no effect on blocks that are currently unlocked. A status output holds the state most recently written into any block. A combinational query port returns the state of any block by index, so that a downstream program or erase gate can decide whether to allow an operation. The number of blocks is a parameter and must be a power of two, at least 2.

Top module: `wp_lock_mgr`

## Requirements
- R1: After reset every block reads locked (3'b010), `wp_status` reads 3'b010, both range registers read 0, and `busy`, `done`, `irq` and `cmd_err` are 0.
- R2: Block states are one-hot: lock-tight = 3'b001, locked = 3'b010, unlocked = 3'b100. `query_state` shows the state of block `query_idx` in the same cycle.
- R3: A write with `first_we` stores `reg_wdata` masked to NUM_BLOCKS-1 into both the first and the last register. A write with `last_we` stores the masked value into the last register only. Both are visible on the following cycle.
- R4: The command codes are 8'h23 (unlock range), 8'h27 (unlock all blocks), 8'h2A (lock range) and 8'h2C (lock-tight range). A range runs from the first register to the last register inclusive, using the values latched when the command is accepted. When first is greater than last, no block changes.
- R5: During unlock and lock commands, a lock-tight block keeps its state.
- R6: During a lock-tight command, an unlocked block keeps its state. Locked blocks become lock-tight.
- R7: `wp_status` takes the new state of each block the walk writes. Blocks that a rule skips leave it unchanged, and so does any cycle without a walk.
- R8: A command is accepted when `cmd_valid` is high and the block is idle. For a known code, `busy` is high from the next cycle for max(1, N) cycles, where N is the number of blocks in range. `done` is high for exactly the one cycle after that. `cmd_valid` is ignored while `busy` or `done` is high.
- R9: `irq` rises in the cycle in which `done` is high and stays high until an `irq_ack` cycle. `irq_ack` clears `irq` and `cmd_err`. A command finishing in the same cycle takes priority over the ack.
- R10: An unknown command code changes no block and raises no `busy`. It gives `done` in the next cycle, with `cmd_err` and `irq` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| first_we | input | 1 | Write first-block register (also sets the last register) |
| last_we | input | 1 | Write last-block register |
| reg_wdata | input | REG_W | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| irq_ack | input | 1 | Clear interrupt request and command error |
| query_idx | input | BLK_W | Block index to query |
| first_blk | output | BLK_W | First-block register |
| last_blk | output | BLK_W | Last-block register |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Sticky interrupt request |
| cmd_err | output | 1 | Sticky command error |
| wp_status | output | 3 | State last written into a block |
| query_state | output | 3 | State of block `query_idx` |

## Verification
The query port is combinational, so its result is due in the same cycle. The bench samples it 3 ns after it changes `query_idx`. Register writes, block states and `wp_status` are due one edge after the cycle that causes them, and `done` and `irq` are due one edge after the last walk cycle. For this reason every comparison runs a few nanoseconds after the falling edge. At that point every register has settled from the preceding rising edge. A behavioural reference model advances on each rising edge from the same input values the design samples, and the bench compares it against every output on every cycle. The scenario checks add walk lengths, counted in `busy` cycles, and per-block state sweeps against hand-computed values.

// File: rtl/wp_lock_pkg.sv
// Shared encodings for the write-protect lock manager.
// Assumes: block states are one-hot; command codes are byte-wide.
package wp_lock_pkg;

    typedef enum logic [2:0] {
        WP_TIGHT    = 3'b001,
        WP_LOCKED   = 3'b010,
        WP_UNLOCKED = 3'b100
    } wp_state_e;

    typedef enum logic [1:0] {
        OP_UNLOCK = 2'd0,
        OP_LOCK   = 2'd1,
        OP_TIGHT  = 2'd2
    } wp_op_e;

    localparam logic [7:0] CMD_UNLOCK_RANGE = 8'h23;
    localparam logic [7:0] CMD_UNLOCK_ALL   = 8'h27;
    localparam logic [7:0] CMD_LOCK_RANGE   = 8'h2A;
    localparam logic [7:0] CMD_TIGHT_RANGE  = 8'h2C;

endpackage

// File: rtl/wp_walk_ctrl.sv
// Command decoder and range walker.
// Accepts one command while idle, latches its bounds and operation,
// then presents one block index per clock until the last one.
// Unknown codes skip the walk and finish at once with a bad flag.
// Assumes: NUM_BLOCKS is a power of two, so the bounds never exceed it.
module wp_walk_ctrl
    import wp_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 64,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    input  logic [BLK_W-1:0] range_lo,
    input  logic [BLK_W-1:0] range_hi,
    output logic             busy,
    output logic             done,
    output logic             finish,
    output logic             bad_cmd,
    output logic             apply,
    output logic [BLK_W-1:0] apply_idx,
    output wp_op_e           apply_op
);

    localparam logic [BLK_W-1:0] LAST_IDX = BLK_W'(NUM_BLOCKS - 1);

    typedef enum logic [1:0] {PH_IDLE, PH_WALK, PH_DONE} phase_e;

    phase_e           phase_q;
    logic [BLK_W-1:0] cur_q, last_q;
    wp_op_e           op_q;

    logic             known;
    wp_op_e           op_n;
    logic [BLK_W-1:0] lo_n, hi_n;
    logic             accept, empty, at_end, walk_fin;

    // Decode the command code into operation and bounds.
    always_comb begin
        known = 1'b1;
        op_n  = OP_UNLOCK;
        lo_n  = range_lo;
        hi_n  = range_hi;
        case (cmd_code)
            CMD_UNLOCK_RANGE: op_n = OP_UNLOCK;
            CMD_UNLOCK_ALL: begin
                op_n = OP_UNLOCK;
                lo_n = '0;
                hi_n = LAST_IDX;
            end
            CMD_LOCK_RANGE:  op_n = OP_LOCK;
            CMD_TIGHT_RANGE: op_n = OP_TIGHT;
            default:         known = 1'b0;
        endcase
    end

    // Walk progress and completion conditions.
    always_comb begin
        accept   = (phase_q == PH_IDLE) && cmd_valid;
        empty    = cur_q > last_q;
        at_end   = cur_q == last_q;
        apply    = (phase_q == PH_WALK) && !empty;
        walk_fin = (phase_q == PH_WALK) && (empty || at_end);
        bad_cmd  = accept && !known;
        finish   = walk_fin || bad_cmd;
    end

    // Phase sequencing and cursor advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cur_q   <= '0;
            last_q  <= '0;
            op_q    <= OP_UNLOCK;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (accept && known) begin
                        phase_q <= PH_WALK;
                        cur_q   <= lo_n;
                        last_q  <= hi_n;
                        op_q    <= op_n;
                    end else if (accept) begin
                        phase_q <= PH_DONE;
                    end
                end
                PH_WALK: begin
                    if (walk_fin) phase_q <= PH_DONE;
                    else          cur_q   <= cur_q + 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy      = phase_q == PH_WALK;
    assign done      = phase_q == PH_DONE;
    assign apply_idx = cur_q;
    assign apply_op  = op_q;

endmodule

// File: rtl/wp_state_array.sv
// Per-block state storage with the stickiness rules applied at the write port.
// One block may be updated per clock; any block can be read combinationally.
// Assumes: indices are always below NUM_BLOCKS (power-of-two count).
module wp_state_array
    import wp_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 64,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply,
    input  logic [BLK_W-1:0] apply_idx,
    input  wp_op_e           apply_op,
    input  logic [BLK_W-1:0] query_idx,
    output logic [2:0]       query_state,
    output logic             upd_fire,
    output logic [2:0]       upd_state
);

    logic [2:0] blk_q [NUM_BLOCKS];
    logic [2:0] target;
    logic       skip;

    // Apply the asymmetric stickiness rules to the addressed block.
    always_comb begin
        target    = blk_q[apply_idx];
        skip      = 1'b1;
        upd_state = WP_LOCKED;
        case (apply_op)
            OP_UNLOCK: begin
                skip      = target == WP_TIGHT;
                upd_state = WP_UNLOCKED;
            end
            OP_LOCK: begin
                skip      = target == WP_TIGHT;
                upd_state = WP_LOCKED;
            end
            OP_TIGHT: begin
                skip      = target == WP_UNLOCKED;
                upd_state = WP_TIGHT;
            end
            default: skip = 1'b1;
        endcase
        upd_fire = apply && !skip;
    end

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
        // Hold one block's state; reset to locked.
        always_ff @(posedge clk) begin
            if (!rst_n)
                blk_q[g] <= WP_LOCKED;
            else if (upd_fire && apply_idx == BLK_W'(g))
                blk_q[g] <= upd_state;
        end
    end

    assign query_state = blk_q[query_idx];

endmodule

// File: rtl/wp_lock_mgr.sv
// Top of the write-protect lock manager.
// Holds the range registers, status, interrupt and error flags, and
// connects the walker to the state array.
// Assumes: NUM_BLOCKS is a power of two, at least 2, and fits in REG_W.
module wp_lock_mgr
    import wp_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 64,
    parameter int REG_W      = 16,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_we,
    input  logic             last_we,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    input  logic             irq_ack,
    input  logic [BLK_W-1:0] query_idx,
    output logic [BLK_W-1:0] first_blk,
    output logic [BLK_W-1:0] last_blk,
    output logic             busy,
    output logic             done,
    output logic             irq,
    output logic             cmd_err,
    output logic [2:0]       wp_status,
    output logic [2:0]       query_state
);

    logic             finish, bad_cmd, apply, upd_fire;
    logic [BLK_W-1:0] apply_idx;
    wp_op_e           apply_op;
    logic [2:0]       upd_state;
    logic [BLK_W-1:0] wdata_masked;

    assign wdata_masked = reg_wdata[BLK_W-1:0];

    wp_walk_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) walk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .range_lo  (first_blk),
        .range_hi  (last_blk),
        .busy      (busy),
        .done      (done),
        .finish    (finish),
        .bad_cmd   (bad_cmd),
        .apply     (apply),
        .apply_idx (apply_idx),
        .apply_op  (apply_op)
    );

    wp_state_array #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) array_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .apply       (apply),
        .apply_idx   (apply_idx),
        .apply_op    (apply_op),
        .query_idx   (query_idx),
        .query_state (query_state),
        .upd_fire    (upd_fire),
        .upd_state   (upd_state)
    );

    // Range registers: a first-block write also sets the last block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_blk <= '0;
            last_blk  <= '0;
        end else begin
            if (first_we) begin
                first_blk <= wdata_masked;
                last_blk  <= wdata_masked;
            end
            if (last_we) last_blk <= wdata_masked;
        end
    end

    // Status follows each block actually written by the walk.
    always_ff @(posedge clk) begin
        if (!rst_n)        wp_status <= WP_LOCKED;
        else if (upd_fire) wp_status <= upd_state;
    end

    // Sticky interrupt and error; completion wins over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            cmd_err <= 1'b0;
        end else begin
            irq     <= finish  || (irq && !irq_ack);
            cmd_err <= bad_cmd || (cmd_err && !irq_ack);
        end
    end

endmodule

// File: rtl/wp_lock_mgr_chk.sv
// Property checker for the lock manager, attached by bind.
// Observes only the top-level ports.
module wp_lock_mgr_chk #(
    parameter int NUM_BLOCKS = 64,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             first_we,
    input logic             last_we,
    input logic             cmd_valid,
    input logic             irq_ack,
    input logic [BLK_W-1:0] first_blk,
    input logic [BLK_W-1:0] last_blk,
    input logic             busy,
    input logic             done,
    input logic             irq,
    input logic [2:0]       wp_status,
    input logic [2:0]       query_state
);

    assert_query_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(query_state) == 1);

    assert_first_mirrors_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (first_we && !last_we) |=> (first_blk == last_blk));

    assert_wp_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(wp_status));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_irq_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> irq);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !busy && !cmd_valid) |=> !irq);

endmodule

bind wp_lock_mgr wp_lock_mgr_chk #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .first_we    (first_we),
    .last_we     (last_we),
    .cmd_valid   (cmd_valid),
    .irq_ack     (irq_ack),
    .first_blk   (first_blk),
    .last_blk    (last_blk),
    .busy        (busy),
    .done        (done),
    .irq         (irq),
    .wp_status   (wp_status),
    .query_state (query_state)
);

// File: tb/wp_lock_mgr_tb_top.sv
// Self-checking bench: behavioural reference model compared every cycle,
// plus scenario checks with hand-computed expectations.
module wp_lock_mgr_tb_top;

    localparam int NB = 64;
    localparam int BW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          first_we = 1'b0, last_we = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = '0;
    logic          irq_ack = 1'b0;
    logic [BW-1:0] query_idx = '0;
    logic [BW-1:0] first_blk, last_blk;
    logic          busy, done, irq, cmd_err;
    logic [2:0]    wp_status, query_state;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    wp_lock_mgr #(.NUM_BLOCKS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .first_we(first_we), .last_we(last_we),
        .reg_wdata(reg_wdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .irq_ack(irq_ack), .query_idx(query_idx), .first_blk(first_blk),
        .last_blk(last_blk), .busy(busy), .done(done), .irq(irq),
        .cmd_err(cmd_err), .wp_status(wp_status), .query_state(query_state)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_blk [NB];
    int m_first, m_last, m_ph, m_cur, m_end, m_op, m_wp, m_irq, m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) m_blk[i] = 2;
            m_first = 0; m_last = 0; m_ph = 0; m_cur = 0; m_end = 0;
            m_op = 0; m_wp = 2; m_irq = 0; m_err = 0;
        end else begin
            if (irq_ack) begin m_irq = 0; m_err = 0; end
            if (m_ph == 0) begin
                if (cmd_valid) begin
                    m_ph = 1; m_cur = m_first; m_end = m_last;
                    if (cmd_code == 8'h23)      m_op = 0;
                    else if (cmd_code == 8'h27) begin m_op = 0; m_cur = 0; m_end = NB - 1; end
                    else if (cmd_code == 8'h2A) m_op = 1;
                    else if (cmd_code == 8'h2C) m_op = 2;
                    else begin m_ph = 2; m_irq = 1; m_err = 1; end
                end
            end else if (m_ph == 1) begin
                if (m_cur > m_end) begin
                    m_ph = 2; m_irq = 1;
                end else begin
                    int s;
                    s = m_blk[m_cur];
                    if (m_op == 2) begin
                        if (s != 4) begin m_blk[m_cur] = 1; m_wp = 1; end
                    end else if (s != 1) begin
                        m_blk[m_cur] = (m_op == 0) ? 4 : 2;
                        m_wp = m_blk[m_cur];
                    end
                    if (m_cur == m_end) begin m_ph = 2; m_irq = 1; end
                    else m_cur++;
                end
            end else begin
                m_ph = 0;
            end
            if (first_we) begin
                m_first = reg_wdata % NB;
                m_last  = reg_wdata % NB;
            end
            if (last_we) m_last = reg_wdata % NB;
        end
    end

    // Compare every output against the model once per cycle.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            check("R8", "busy", busy, m_ph == 1);
            check("R8", "done", done, m_ph == 2);
            check("R9", "irq", irq, m_irq);
            check("R10", "cmd_err", cmd_err, m_err);
            check("R7", "wp_status", wp_status, m_wp);
            check("R2", "query_state", query_state, m_blk[query_idx]);
            check("R3", "first_blk", first_blk, m_first);
            check("R3", "last_blk", last_blk, m_last);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_first(input int v);
        @(negedge clk); first_we = 1'b1; reg_wdata = 16'(v);
        @(negedge clk); first_we = 1'b0;
    endtask

    task automatic wr_last(input int v);
        @(negedge clk); last_we = 1'b1; reg_wdata = 16'(v);
        @(negedge clk); last_we = 1'b0;
    endtask

    task automatic run_cmd(input logic [7:0] code, output int nbusy);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = code;
        @(negedge clk); cmd_valid = 1'b0;
        nbusy = 0;
        while (!done) begin
            if (busy) nbusy++;
            @(negedge clk);
        end
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic expect_blocks(input int lo, input int hi, input int exp, input string tag);
        for (int i = lo; i <= hi; i++) begin
            @(negedge clk); query_idx = BW'(i); #3;
            check(tag, "block state", query_state, exp);
        end
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int nb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        // R1 reset state
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "irq", irq, 0);
        check("R1", "cmd_err", cmd_err, 0);
        check("R1", "wp_status", wp_status, 2);
        check("R1", "first_blk", first_blk, 0);
        check("R1", "last_blk", last_blk, 0);
        expect_blocks(0, NB - 1, 2, "R1");

        // R3 register writes with masking
        wr_first(16'h1234); #1;
        check("R3", "first masked", first_blk, 52);
        check("R3", "last mirrored", last_blk, 52);
        wr_last(16'hFFC5); #1;
        check("R3", "last only", last_blk, 5);
        check("R3", "first kept", first_blk, 52);

        // R4 unlock range 3..6
        wr_first(3); wr_last(6);
        run_cmd(8'h23, nb);
        check("R8", "walk length", nb, 4);
        check("R9", "irq at done", irq, 1);
        check("R7", "status after unlock", wp_status, 4);
        expect_blocks(3, 6, 4, "R4");
        expect_blocks(0, 2, 2, "R4");
        expect_blocks(7, 7, 2, "R4");
        check("R9", "irq held", irq, 1);
        ack(); #1;
        check("R9", "irq cleared", irq, 0);

        // R6 lock-tight 2..4: 2 becomes tight, 3 and 4 stay unlocked
        wr_first(2); wr_last(4);
        run_cmd(8'h2C, nb);
        check("R8", "walk length", nb, 3);
        check("R7", "status last written", wp_status, 1);
        expect_blocks(2, 2, 1, "R6");
        expect_blocks(3, 4, 4, "R6");
        ack();

        // R5 lock 0..6: tight block 2 unchanged
        wr_first(0); wr_last(6);
        run_cmd(8'h2A, nb);
        check("R7", "status after lock", wp_status, 2);
        expect_blocks(2, 2, 1, "R5");
        expect_blocks(3, 6, 2, "R5");
        ack();

        // R4/R5 unlock all
        run_cmd(8'h27, nb);
        check("R8", "walk length all", nb, NB);
        expect_blocks(0, 1, 4, "R4");
        expect_blocks(2, 2, 1, "R5");
        expect_blocks(3, NB - 1, 4, "R4");
        ack();

        // R8 command during walk ignored
        wr_first(10); wr_last(20);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h2A;
        @(negedge clk); cmd_code = 8'h2C;
        @(negedge clk); cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk); #1;
        check("R8", "no second command", busy, 0);
        expect_blocks(10, 20, 2, "R8");
        expect_blocks(21, 21, 4, "R8");
        ack();

        // R4 empty range: first > last
        wr_first(30); wr_last(25);
        run_cmd(8'h2A, nb);
        check("R8", "empty walk length", nb, 1);
        check("R7", "status unchanged", wp_status, 2);
        expect_blocks(25, 30, 4, "R4");
        ack();

        // R10 unknown command
        run_cmd(8'h55, nb);
        check("R10", "no busy", nb, 0);
        check("R10", "cmd_err", cmd_err, 1);
        check("R10", "irq", irq, 1);
        expect_blocks(0, 1, 4, "R10");
        ack(); #1;
        check("R9", "err cleared", cmd_err, 0);
        check("R9", "irq cleared", irq, 0);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule